// File: doc/BRIEF.md
# Time-Locked Pulse Train Generator

This block makes a periodic pulse output that is phase-locked to a free-running time-of-day count. The time base comes from outside the block as a seconds value, a nanoseconds value and a tick strobe. The strobe marks each sub-second increment step. Software programs the block through a small write/read register port. It sets an absolute start time, a period and a high time, both counted in ticks and both written as the count minus one. It then issues start and stop commands through a packed control field.

A start command arms the channel. The first pulse begins on the first tick at which the time of day has reached the programmed start time. Pulses then repeat until a stop command arrives. While a newly written target time is still pending, a busy flag protects it from being rewritten. A target-mode field chooses the behaviour at the target: a visible pulse train, or only a one-cycle event strobe with the output kept low.

Top module: `ptg_pulse_train`

## Requirements
- R1: After reset, `pulse_out` and `trig_evt` are low, every register reads zero and the busy flag is clear.
- R2: The register addresses are: 0 control, 1 target seconds, 2 target nanoseconds, 3 interval, 4 width. In the control word, the command sits in bits [3:0], the target mode in bits [7:6] and the global enable in bit 31. Interval, width and target seconds read back as written. The command bits always read back as zero.
- R3: Bit 31 of the target-nanoseconds register is a read-only busy flag. A write to that register sets the flag. The flag clears on the first tick at which (seconds, nanoseconds) of the time of day is greater than or equal to the target.
- R4: While busy is set, writes to the target-seconds and target-nanoseconds registers are ignored.
- R5: A start command (code 4'b0010) written together with enable = 1 arms an idle channel. The train begins at the clock edge that sees a tick with the time of day at or past the target. From that edge `pulse_out` is high. If the target is already in the past, the train begins on the next tick.
- R6: Once running, the train repeats every interval+1 ticks. The output stays high for width+1 ticks of each period, counted from the start of that period.
- R7: When width is greater than or equal to interval, `pulse_out` stays high without a break, including across each period wrap.
- R8: A start command is ignored while the interval register holds a value below 3, that is, a period shorter than four ticks.
- R9: A stop command (code 4'b0101) written with enable = 1 ends the train or the armed state. `pulse_out` is low from the next clock edge onward.
- R10: A command written with enable = 0 has no effect. Command codes other than start and stop have no effect.
- R11: With target mode 2'b10, the train appears on `pulse_out`. With any other mode, `pulse_out` stays low. In every mode, `trig_evt` is high for exactly one cycle at the edge where the armed channel triggers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tod_sec | input | SEC_W | Time-of-day seconds |
| tod_ns | input | NS_W | Time-of-day nanoseconds |
| tod_tick | input | 1 | One-cycle strobe per sub-second increment |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Read data for rd_addr, combinational |
| pulse_out | output | 1 | Pulse train output |
| trig_evt | output | 1 | One-cycle strobe when the armed channel triggers |

## Verification
The assertions assume that interval, width and target mode are held steady while a train runs. They also assume that a target-nanoseconds write never falls on the same cycle as a tick that would meet the old target. The checks on counter stepping and on the unbroken high level depend on these assumptions.

The stimulus respects them. Every reprogramming of interval, width or mode is preceded by a stop command. Target writes happen only at known points well away from the target. The time-of-day model advances by a fixed step on every second cycle and never crosses a second boundary during the run.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    // register addresses; the bench and software rely on these
    localparam int          REG_AW   = 3;
    localparam logic [2:0]  RA_CTRL  = 3'd0;
    localparam logic [2:0]  RA_TSEC  = 3'd1;
    localparam logic [2:0]  RA_TNS   = 3'd2;
    localparam logic [2:0]  RA_IVAL  = 3'd3;
    localparam logic [2:0]  RA_WID   = 3'd4;

    // control field layout: command low nibble, mode in top two bits of the byte
    localparam int          CMD_LSB  = 0;
    localparam int          CMD_W    = 4;
    localparam int          MODE_LSB = 6;
    localparam int          MODE_W   = 2;

    localparam logic [3:0]  CMD_START = 4'b0010;
    localparam logic [3:0]  CMD_STOP  = 4'b0101;

    localparam logic [1:0]  TM_TRAIN  = 2'b10;

    // smallest legal interval value (period of four ticks)
    localparam int          MIN_IVAL  = 3;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_RUN   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ptg_time_cmp.sv
module ptg_time_cmp #(
    parameter int SEC_W = 32,
    parameter int NS_W  = 30
) (
    input  logic [SEC_W-1:0] now_sec,
    input  logic [NS_W-1:0]  now_ns,
    input  logic [SEC_W-1:0] tgt_sec,
    input  logic [NS_W-1:0]  tgt_ns,
    output logic             reached
);
    logic sec_gt;
    logic sec_eq;
    logic ns_ge;

    always_comb begin
        sec_gt  = now_sec > tgt_sec;
        sec_eq  = now_sec == tgt_sec;
        ns_ge   = now_ns >= tgt_ns;
        reached = sec_gt || (sec_eq && ns_ge);
    end
endmodule

// File: rtl/ptg_regs.sv
module ptg_regs
    import ptg_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int NS_W   = 30,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    input  logic              tick,
    input  logic              reached,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEC_W-1:0]  tgt_sec,
    output logic [NS_W-1:0]   tgt_ns,
    output logic [CNT_W-1:0]  ival,
    output logic [CNT_W-1:0]  wid,
    output logic [1:0]        mode,
    output logic              busy,
    output logic              start_req,
    output logic              stop_req
);
    localparam int EN_BIT   = DATA_W - 1;
    localparam int BUSY_BIT = DATA_W - 1;

    typedef struct packed {
        logic [SEC_W-1:0] tsec;
        logic [NS_W-1:0]  tns;
        logic [CNT_W-1:0] ival;
        logic [CNT_W-1:0] wid;
        logic             en;
        logic [1:0]       mode;
        logic             busy;
    } reg_s;

    reg_s             r_d;
    reg_s             r_q;
    logic [CMD_W-1:0] cmd_w;
    logic             en_w;
    logic             ival_ok;
    logic             unused_bits;

    assign unused_bits = ^wr_data;

    always_comb begin
        cmd_w   = wr_data[CMD_LSB +: CMD_W];
        en_w    = wr_data[EN_BIT];
        ival_ok = r_q.ival >= CNT_W'(MIN_IVAL);

        r_d       = r_q;
        start_req = 1'b0;
        stop_req  = 1'b0;

        if (wr_en) begin
            case (wr_addr)
                RA_CTRL: begin
                    r_d.en   = en_w;
                    r_d.mode = wr_data[MODE_LSB +: MODE_W];
                    if (en_w && (cmd_w == CMD_START) && ival_ok) begin
                        start_req = 1'b1;
                    end
                    if (en_w && (cmd_w == CMD_STOP)) begin
                        stop_req = 1'b1;
                    end
                end
                RA_TSEC: begin
                    if (!r_q.busy) begin
                        r_d.tsec = wr_data[SEC_W-1:0];
                    end
                end
                RA_TNS: begin
                    if (!r_q.busy) begin
                        r_d.tns  = wr_data[NS_W-1:0];
                        r_d.busy = 1'b1;
                    end
                end
                RA_IVAL: r_d.ival = wr_data[CNT_W-1:0];
                RA_WID:  r_d.wid  = wr_data[CNT_W-1:0];
                default: ;
            endcase
        end

        // pending target matured on this tick
        if (r_q.busy && tick && reached) begin
            r_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_CTRL: begin
                rd_data[EN_BIT]                 = r_q.en;
                rd_data[MODE_LSB +: MODE_W]     = r_q.mode;
            end
            RA_TSEC: rd_data[SEC_W-1:0] = r_q.tsec;
            RA_TNS: begin
                rd_data[NS_W-1:0] = r_q.tns;
                rd_data[BUSY_BIT] = r_q.busy;
            end
            RA_IVAL: rd_data[CNT_W-1:0] = r_q.ival;
            RA_WID:  rd_data[CNT_W-1:0] = r_q.wid;
            default: rd_data = '0;
        endcase
    end

    assign tgt_sec = r_q.tsec;
    assign tgt_ns  = r_q.tns;
    assign ival    = r_q.ival;
    assign wid     = r_q.wid;
    assign mode    = r_q.mode;
    assign busy    = r_q.busy;
endmodule

// File: rtl/ptg_seq.sv
module ptg_seq
    import ptg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reached,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic [CNT_W-1:0] ival,
    input  logic [CNT_W-1:0] wid,
    input  logic [1:0]       mode,
    output logic             pulse_out,
    output logic             trig_evt,
    output logic             run,
    output logic             armed,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             out;
        logic             evt;
    } seq_s;

    seq_s s_d;
    seq_s s_q;

    always_comb begin
        s_d     = s_q;
        s_d.evt = 1'b0;

        case (s_q.state)
            SQ_IDLE: begin
                if (start_req) begin
                    s_d.state = SQ_ARMED;
                end
            end
            SQ_ARMED: begin
                if (tick && reached) begin
                    s_d.state = SQ_RUN;
                    s_d.cnt   = '0;
                    s_d.evt   = 1'b1;
                end
            end
            SQ_RUN: begin
                if (tick) begin
                    s_d.cnt = (s_q.cnt >= ival) ? '0 : s_q.cnt + CNT_W'(1);
                end
            end
            default: s_d.state = SQ_IDLE;
        endcase

        if (stop_req) begin
            s_d.state = SQ_IDLE;
            s_d.cnt   = '0;
            s_d.evt   = 1'b0;
        end

        // output decided from next state so it changes only at one edge
        s_d.out = (s_d.state == SQ_RUN) && (mode == TM_TRAIN) && (s_d.cnt <= wid);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: SQ_IDLE, cnt: '0, out: 1'b0, evt: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse_out = s_q.out;
    assign trig_evt  = s_q.evt;
    assign run       = s_q.state == SQ_RUN;
    assign armed     = s_q.state == SQ_ARMED;
    assign cnt       = s_q.cnt;
endmodule

// File: rtl/ptg_pulse_train.sv
module ptg_pulse_train
    import ptg_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int NS_W   = 30,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  tod_sec,
    input  logic [NS_W-1:0]   tod_ns,
    input  logic              tod_tick,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pulse_out,
    output logic              trig_evt
);
    logic [SEC_W-1:0] tsec_w;
    logic [NS_W-1:0]  tns_w;
    logic [CNT_W-1:0] ival_w;
    logic [CNT_W-1:0] wid_w;
    logic [1:0]       mode_w;
    logic             busy_w;
    logic             start_w;
    logic             stop_w;
    logic             reached_w;
    logic             run_w;
    logic             armed_w;
    logic [CNT_W-1:0] cnt_w;

    ptg_time_cmp #(.SEC_W(SEC_W), .NS_W(NS_W)) u_cmp (
        .now_sec (tod_sec),
        .now_ns  (tod_ns),
        .tgt_sec (tsec_w),
        .tgt_ns  (tns_w),
        .reached (reached_w)
    );

    ptg_regs #(.SEC_W(SEC_W), .NS_W(NS_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .tick      (tod_tick),
        .reached   (reached_w),
        .rd_data   (rd_data),
        .tgt_sec   (tsec_w),
        .tgt_ns    (tns_w),
        .ival      (ival_w),
        .wid       (wid_w),
        .mode      (mode_w),
        .busy      (busy_w),
        .start_req (start_w),
        .stop_req  (stop_w)
    );

    ptg_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tod_tick),
        .reached   (reached_w),
        .start_req (start_w),
        .stop_req  (stop_w),
        .ival      (ival_w),
        .wid       (wid_w),
        .mode      (mode_w),
        .pulse_out (pulse_out),
        .trig_evt  (trig_evt),
        .run       (run_w),
        .armed     (armed_w),
        .cnt       (cnt_w)
    );
endmodule

// File: rtl/ptg_pulse_train_chk.sv
module ptg_pulse_train_chk
    import ptg_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int NS_W   = 30,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              tod_tick,
    input logic              pulse_out,
    input logic              trig_evt,
    input logic              run,
    input logic              armed,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  ival,
    input logic [CNT_W-1:0]  wid,
    input logic [1:0]        mode,
    input logic              busy,
    input logic [SEC_W-1:0]  tsec,
    input logic [NS_W-1:0]   tns
);
    logic ctl_wr;
    logic en_bit;
    logic [3:0] cmd;
    logic unused_chk;

    assign ctl_wr     = wr_en && (wr_addr == RA_CTRL);
    assign en_bit     = wr_data[DATA_W-1];
    assign cmd        = wr_data[3:0];
    assign unused_chk = ^wr_data;

    assert_out_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> run);

    assert_evt_from_armed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trig_evt |-> (run && $past(armed)));

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tod_tick && (cnt >= ival)) |=> (cnt == '0));

    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tod_tick && (cnt < ival)) |=> (!run || (cnt == $past(cnt) + CNT_W'(1))));

    assert_full_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (mode == TM_TRAIN) && $stable(mode) && (wid >= ival)
         && $stable(wid) && $stable(ival)) |-> pulse_out);

    assert_busy_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == RA_TNS) && !busy) |=> busy);

    assert_tsec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == RA_TSEC) && busy) |=> $stable(tsec));

    assert_tns_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == RA_TNS) && busy) |=> $stable(tns));

    assert_short_ival_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !armed && ctl_wr && (cmd == CMD_START) && (ival < CNT_W'(MIN_IVAL)))
        |=> (!run && !armed));

    assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && en_bit && (cmd == CMD_STOP)) |=> (!pulse_out && !run && !armed));
endmodule

bind ptg_pulse_train ptg_pulse_train_chk #(
    .SEC_W(SEC_W), .NS_W(NS_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tod_tick  (tod_tick),
    .pulse_out (pulse_out),
    .trig_evt  (trig_evt),
    .run       (run_w),
    .armed     (armed_w),
    .cnt       (cnt_w),
    .ival      (ival_w),
    .wid       (wid_w),
    .mode      (mode_w),
    .busy      (busy_w),
    .tsec      (tsec_w),
    .tns       (tns_w)
);

// File: tb/tb_ptg_pulse_train.sv
module tb_ptg_pulse_train;
    localparam int SEC_W  = 32;
    localparam int NS_W   = 30;
    localparam int CNT_W  = 32;
    localparam int DATA_W = 32;
    localparam int NS_INC = 20;
    localparam int NVEC   = 6;
    localparam int NPER   = 3;
    // interval in [15:8], width in [7:0]
    localparam logic [15:0] VECS [NVEC] = '{16'h0301, 16'h0904, 16'h0700,
                                            16'h0505, 16'h0409, 16'h0F07};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SEC_W-1:0]  tod_sec = 32'd5;
    logic [NS_W-1:0]   tod_ns = '0;
    logic              tod_tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [2:0]        rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              pulse_out;
    logic              trig_evt;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    ptg_pulse_train #(.SEC_W(SEC_W), .NS_W(NS_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_tick(tod_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pulse_out(pulse_out), .trig_evt(trig_evt)
    );

    always #10 clk = ~clk;

    // time of day: advances one step every second cycle, tick marks the step
    initial begin
        bit ph;
        ph = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            ph = ~ph;
            if (ph) begin
                if (int'(tod_ns) + NS_INC >= 1000000000) begin
                    tod_ns  = NS_W'(int'(tod_ns) + NS_INC - 1000000000);
                    tod_sec = tod_sec + 1;
                end else begin
                    tod_ns = tod_ns + NS_W'(NS_INC);
                end
                tod_tick = 1'b1;
            end else begin
                tod_tick = 1'b0;
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] ctl(bit en, logic [1:0] md, logic [3:0] c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DATA_W-1] = en;
        w[7:6] = md;
        w[3:0] = c;
        return w;
    endfunction

    task automatic wr(logic [2:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // counts high samples and trigger strobes over n cycles
    task automatic watch(int n, output int highs, output int evts);
        highs = 0; evts = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pulse_out) highs++;
            if (trig_evt) evts++;
        end
    endtask

    initial begin
        logic [DATA_W-1:0] d;
        logic [NS_W-1:0] tgt;
        int highs, evts, rises, wcyc, found;
        bit prev;

        // reset state
        repeat (3) @(negedge clk);
        check("R1 pulse_out in reset", pulse_out, 0);
        check("R1 trig_evt in reset", trig_evt, 0);
        rst_n = 1'b1;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            check($sformatf("R1 reg %0d after reset", a), d, 0);
        end

        // readback
        wr(3'd3, 32'd9);
        wr(3'd4, 32'd4);
        wr(3'd1, 32'd5);
        rd(3'd3, d); check("R2 interval readback", d, 9);
        rd(3'd4, d); check("R2 width readback", d, 4);
        rd(3'd1, d); check("R2 target seconds readback", d, 5);

        // future target, busy handshake, exact trigger point
        tgt = tod_ns + NS_W'(400);
        wr(3'd2, DATA_W'(tgt));
        rd(3'd2, d); check("R3 busy set after target write", d, (64'd1 << 31) | tgt);
        wr(3'd1, 32'd7);
        rd(3'd1, d); check("R4 seconds write while busy ignored", d, 5);
        wr(3'd2, 32'd1);
        rd(3'd2, d); check("R4 nanoseconds write while busy ignored", d, (64'd1 << 31) | tgt);
        wr(3'd0, ctl(1'b1, 2'b10, 4'b0010));
        rd(3'd0, d); check("R2 control readback, command reads zero", d, 32'h8000_0080);
        check("R5 output low while armed before target", pulse_out, 0);
        rd_addr = 3'd2;
        found = 0;
        for (int k = 0; k < 200 && found == 0; k++) begin
            @(negedge clk);
            if (!rd_data[31]) begin
                found = 1;
                check("R5 output rises with target match", pulse_out, 1);
                check("R3 busy clears at first tick at target", int'(tod_ns) >= int'(tgt), 1);
                check("R3 busy does not clear late", int'(tod_ns) - NS_INC < int'(tgt), 1);
            end
        end
        check("R3 busy cleared", found, 1);

        // stop
        wr(3'd0, ctl(1'b1, 2'b10, 4'b0101));
        check("R9 output low after stop", pulse_out, 0);
        watch(60, highs, evts);
        check("R9 no pulses after stop", highs, 0);

        // table of interval/width pairs, target in the past
        for (int i = 0; i < NVEC; i++) begin
            int iv, wd, exp_h, exp_r;
            iv = int'(VECS[i][15:8]);
            wd = int'(VECS[i][7:0]);
            wr(3'd0, ctl(1'b1, 2'b10, 4'b0101));
            wr(3'd3, DATA_W'(iv));
            wr(3'd4, DATA_W'(wd));
            wr(3'd0, ctl(1'b1, 2'b10, 4'b0010));
            prev = 1'b0;
            found = 0;
            for (int k = 0; k < 100 && found == 0; k++) begin
                @(negedge clk);
                if (pulse_out && !prev) found = 1;
                prev = pulse_out;
            end
            check($sformatf("R5 train starts, vector %0d", i), found, 1);
            wcyc = 2 * (iv + 1) * NPER;
            highs = 1; rises = 1; prev = 1'b1;
            for (int k = 1; k < wcyc; k++) begin
                @(negedge clk);
                if (pulse_out) highs++;
                if (pulse_out && !prev) rises++;
                prev = pulse_out;
            end
            exp_h = 2 * (((wd >= iv) ? iv : wd) + 1) * NPER;
            exp_r = (wd >= iv) ? 1 : NPER;
            if (wd >= iv) begin
                check($sformatf("R7 steady high cycles, vector %0d", i), highs, exp_h);
                check($sformatf("R7 no gap at wrap, vector %0d", i), rises, exp_r);
            end else begin
                check($sformatf("R6 high cycles, vector %0d", i), highs, exp_h);
                check($sformatf("R6 period count, vector %0d", i), rises, exp_r);
            end
        end

        // interval too short
        wr(3'd0, ctl(1'b1, 2'b10, 4'b0101));
        wr(3'd3, 32'd2);
        wr(3'd4, 32'd0);
        wr(3'd0, ctl(1'b1, 2'b10, 4'b0010));
        watch(40, highs, evts);
        check("R8 short interval, no output", highs, 0);
        check("R8 short interval, no trigger", evts, 0);

        // enable low and unknown codes
        wr(3'd3, 32'd5);
        wr(3'd4, 32'd2);
        wr(3'd0, ctl(1'b0, 2'b10, 4'b0010));
        watch(40, highs, evts);
        check("R10 start without enable ignored", highs + evts, 0);
        wr(3'd0, ctl(1'b1, 2'b10, 4'b0011));
        watch(40, highs, evts);
        check("R10 unknown code ignored", highs + evts, 0);
        wr(3'd0, ctl(1'b1, 2'b10, 4'b0010));
        watch(20, highs, evts);
        check("R10 valid start then runs", evts, 1);
        wr(3'd0, ctl(1'b0, 2'b10, 4'b0101));
        watch(40, highs, evts);
        check("R10 stop without enable ignored", highs > 0, 1);

        // interrupt-only mode
        wr(3'd0, ctl(1'b1, 2'b10, 4'b0101));
        wr(3'd0, ctl(1'b1, 2'b00, 4'b0010));
        watch(40, highs, evts);
        check("R11 event strobe once in interrupt mode", evts, 1);
        check("R11 output stays low in interrupt mode", highs, 0);
        wr(3'd0, ctl(1'b1, 2'b00, 4'b0101));

        done = 1'b1;
        summary();
        $finish;
    end
endmodule